// File: doc/BRIEF.md
# Pipeline Hazard and Operand Bypass Controller

This block is the hazard control for a five-stage in-order integer pipeline. The stages, in order, are fetch, decode with register read, ALU, memory and write-back. Each cycle the decode stage presents its register fields, a write-address select, a write enable and a load flag. The ALU stage presents whether a branch or jump it is resolving is taken. The controller keeps its own copy of the register-number fields as the instructions move from the ALU stage to write-back. From that copy it drives three kinds of output: the operand bypass selects for the instruction in the ALU stage, the hold and bubble controls for a load-use dependence, and the flush controls for a taken branch. It also gives the register-file write port its destination number and enable.

Each cycle is classified by a single action. RUN means every stage advances. STALL is taken when the ALU stage holds a load whose live destination is read by the decode instruction. In that case the program counter and the fetch/decode register hold, and a no-op enters the ALU stage. FLUSH is taken when the ALU stage reports a taken branch. The fetched and decoded instructions are then replaced by no-ops. FLUSH wins over STALL, and STALL wins over RUN. The action is recomputed from scratch every cycle: RUN→STALL on a load-use match, STALL→RUN on the next cycle (the bubble has removed the load from the ALU stage), and any→FLUSH whenever a taken branch is reported.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: The destination number travels with the instruction and appears on wb_wa with wb_we three clock edges after the instruction is presented at decode. The 2-bit select picks the value: 00 gives the rd field, 01 the rt field, 10 the constant 31, 11 the constant 27.
- R2: An ALU-stage source that equals the live destination of the instruction one ahead (in the memory stage) gets bypass code 10. There is one code per operand: fwd_a for the first source and fwd_b for the second.
- R3: An ALU-stage source that equals the live destination of the instruction two ahead (in write-back) gets bypass code 01. Otherwise the code is 00, meaning the register-file value.
- R4: When both the memory stage and the write-back stage match a source, the code is 10, so the younger result wins.
- R5: A destination of register 0, or an older instruction with its write enable low, never causes a bypass or a stall.
- R6: A load in the ALU stage whose live destination equals the decode rs or rt raises pc_hold, ifid_hold and idex_bubble in that same cycle.
- R7: The stall lasts one cycle only. After the bubble, the dependent instruction reaches the ALU stage with bypass code 01 from the load in write-back.
- R8: A taken-branch flag raises ifid_flush and idex_flush. The instruction then in decode never writes a register.
- R9: Flush takes priority over stall in the same cycle: the hold and bubble outputs stay low.
- R10: During and right after reset, all bypass codes are 00, and the hold, bubble, flush and wb_we outputs are low.
- R11: A producer in the ALU stage that is not a load never causes a stall. Its result is bypassed later instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| id_rs | input | 5 | First source register of the decode instruction |
| id_rt | input | 5 | Second source register (rt field) of the decode instruction |
| id_rd | input | 5 | rd field of the decode instruction |
| id_wa_sel | input | 2 | Destination select: 00 rd, 01 rt, 10 reg 31, 11 reg 27 |
| id_reg_we | input | 1 | Decode instruction writes a register |
| id_is_load | input | 1 | Decode instruction is a load |
| ex_br_taken | input | 1 | ALU-stage branch or jump is taken |
| fwd_a | output | 2 | Bypass select, first ALU operand |
| fwd_b | output | 2 | Bypass select, second ALU operand |
| pc_hold | output | 1 | Program counter keeps its value |
| ifid_hold | output | 1 | Fetch/decode register keeps its value |
| idex_bubble | output | 1 | Decode/ALU register loads a no-op (stall) |
| ifid_flush | output | 1 | Fetch/decode register loads a no-op |
| idex_flush | output | 1 | Decode/ALU register loads a no-op (flush) |
| wb_wa | output | 5 | Register-file write address |
| wb_we | output | 1 | Register-file write enable |

## Verification
The bound checker watches several rules on every cycle. Flush always overrides the hold and bubble outputs. The three stall outputs always move together. A stall never lasts two cycles in a row. The cycle after a taken branch always finds a dead instruction in the ALU stage. A source of register 0 is never bypassed. A load in the memory stage is never the chosen bypass source. Other behaviours can only be shown by the bench's instruction sequences: the exact bypass code for producer/consumer gaps of one and two, the four destination choices arriving at write-back, the cycle count of the load-use stall and the bypass that follows it, and the suppression of register writes by a flushed instruction.

// File: rtl/hz_pkg.sv
package hz_pkg;
    localparam int REG_AW = 5;

    typedef logic [REG_AW-1:0] reg_id_t;

    typedef enum logic [1:0] {
        WA_RD   = 2'b00,
        WA_RT   = 2'b01,
        WA_LINK = 2'b10,
        WA_TRAP = 2'b11
    } wa_sel_e;

    typedef enum logic [1:0] {
        FWD_RF  = 2'b00,
        FWD_WB  = 2'b01,
        FWD_MEM = 2'b10
    } fwd_e;

    typedef enum logic [1:0] {
        ACT_RUN,
        ACT_STALL,
        ACT_FLUSH
    } act_e;

    // slot held in the decode/ALU register
    typedef struct packed {
        reg_id_t rs;
        reg_id_t rt;
        reg_id_t wa;
        logic    we;
        logic    load;
    } ex_slot_t;

    // slot held in the later registers
    typedef struct packed {
        reg_id_t wa;
        logic    we;
        logic    load;
    } dst_slot_t;

    localparam ex_slot_t EX_NOP = '{rs: '0, rt: '0, wa: '0, we: 1'b0, load: 1'b0};
endpackage

// File: rtl/hz_dest_sel.sv
module hz_dest_sel
    import hz_pkg::*;
#(
    parameter int LINK_REG = 31,
    parameter int TRAP_REG = 27
) (
    input  logic [1:0] sel,
    input  reg_id_t    rd,
    input  reg_id_t    rt,
    output reg_id_t    wa
);
    localparam reg_id_t LINK_ID = reg_id_t'(LINK_REG);
    localparam reg_id_t TRAP_ID = reg_id_t'(TRAP_REG);

    always_comb begin
        unique case (wa_sel_e'(sel))
            WA_RD:   wa = rd;
            WA_RT:   wa = rt;
            WA_LINK: wa = LINK_ID;
            WA_TRAP: wa = TRAP_ID;
            default: wa = rd;
        endcase
    end
endmodule

// File: rtl/hz_fwd_pick.sv
module hz_fwd_pick
    import hz_pkg::*;
(
    input  reg_id_t    src,
    input  dst_slot_t  mem_s,
    input  dst_slot_t  wb_s,
    output logic [1:0] sel
);
    logic mem_hit;
    logic wb_hit;

    assign mem_hit = mem_s.we && (mem_s.wa != '0) && (mem_s.wa == src);
    assign wb_hit  = wb_s.we  && (wb_s.wa  != '0) && (wb_s.wa  == src);

    always_comb begin
        if (mem_hit)     sel = FWD_MEM;
        else if (wb_hit) sel = FWD_WB;
        else             sel = FWD_RF;
    end
endmodule

// File: rtl/hz_stage_track.sv
module hz_stage_track
    import hz_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  act_e      act,
    input  ex_slot_t  id_s,
    output ex_slot_t  ex_q,
    output dst_slot_t mem_q,
    output dst_slot_t wb_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ex_q  <= EX_NOP;
            mem_q <= '0;
            wb_q  <= '0;
        end else begin
            unique case (act)
                ACT_RUN:   ex_q <= id_s;
                ACT_STALL: ex_q <= EX_NOP;
                ACT_FLUSH: ex_q <= EX_NOP;
                default:   ex_q <= EX_NOP;
            endcase
            mem_q <= '{wa: ex_q.wa, we: ex_q.we, load: ex_q.load};
            wb_q  <= mem_q;
        end
    end
endmodule

// File: rtl/pipe_hazard_ctl.sv
module pipe_hazard_ctl
    import hz_pkg::*;
#(
    parameter int LINK_REG = 31,
    parameter int TRAP_REG = 27
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [4:0] id_rs,
    input  logic [4:0] id_rt,
    input  logic [4:0] id_rd,
    input  logic [1:0] id_wa_sel,
    input  logic       id_reg_we,
    input  logic       id_is_load,
    input  logic       ex_br_taken,
    output logic [1:0] fwd_a,
    output logic [1:0] fwd_b,
    output logic       pc_hold,
    output logic       ifid_hold,
    output logic       idex_bubble,
    output logic       ifid_flush,
    output logic       idex_flush,
    output logic [4:0] wb_wa,
    output logic       wb_we
);
    localparam int NUM_SRC = 2;

    reg_id_t   id_wa;
    ex_slot_t  id_s;
    ex_slot_t  ex_q;
    dst_slot_t mem_q;
    dst_slot_t wb_q;
    act_e      act;
    logic      use_hit;

    // plain views of tracked state
    logic    ex_we;
    logic    mem_is_load;
    reg_id_t ex_rs;
    reg_id_t ex_rt;
    assign ex_we       = ex_q.we;
    assign mem_is_load = mem_q.load;
    assign ex_rs       = ex_q.rs;
    assign ex_rt       = ex_q.rt;

    hz_dest_sel #(.LINK_REG(LINK_REG), .TRAP_REG(TRAP_REG)) u_dest (
        .sel (id_wa_sel),
        .rd  (id_rd),
        .rt  (id_rt),
        .wa  (id_wa)
    );

    assign id_s = '{rs: id_rs, rt: id_rt, wa: id_wa, we: id_reg_we, load: id_is_load};

    // load-use detection against the ALU-stage load
    assign use_hit = ex_q.load && ex_q.we && (ex_q.wa != '0) &&
                     ((ex_q.wa == id_rs) || (ex_q.wa == id_rt));

    always_comb begin
        if (ex_br_taken)  act = ACT_FLUSH;
        else if (use_hit) act = ACT_STALL;
        else              act = ACT_RUN;
    end

    // output process
    always_comb begin
        pc_hold     = 1'b0;
        ifid_hold   = 1'b0;
        idex_bubble = 1'b0;
        ifid_flush  = 1'b0;
        idex_flush  = 1'b0;
        unique case (act)
            ACT_RUN: begin
            end
            ACT_STALL: begin
                pc_hold     = 1'b1;
                ifid_hold   = 1'b1;
                idex_bubble = 1'b1;
            end
            ACT_FLUSH: begin
                ifid_flush  = 1'b1;
                idex_flush  = 1'b1;
            end
            default: begin
            end
        endcase
    end

    hz_stage_track u_track (
        .clk   (clk),
        .rst_n (rst_n),
        .act   (act),
        .id_s  (id_s),
        .ex_q  (ex_q),
        .mem_q (mem_q),
        .wb_q  (wb_q)
    );

    reg_id_t    ex_src  [NUM_SRC];
    logic [1:0] fwd_sel [NUM_SRC];
    assign ex_src[0] = ex_rs;
    assign ex_src[1] = ex_rt;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_fwd
        hz_fwd_pick u_pick (
            .src   (ex_src[g]),
            .mem_s (mem_q),
            .wb_s  (wb_q),
            .sel   (fwd_sel[g])
        );
    end

    assign fwd_a = fwd_sel[0];
    assign fwd_b = fwd_sel[1];
    assign wb_wa = wb_q.wa;
    assign wb_we = wb_q.we;
endmodule

// File: rtl/hz_chk.sv
module hz_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] fwd_a,
    input logic [1:0] fwd_b,
    input logic       pc_hold,
    input logic       ifid_hold,
    input logic       idex_bubble,
    input logic       ifid_flush,
    input logic       ex_br_taken,
    input logic       ex_we,
    input logic [4:0] ex_rs,
    input logic       mem_is_load
);
    // R9
    flush_over_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ifid_flush |-> (!pc_hold && !idex_bubble));

    // R6
    hold_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_hold == ifid_hold) && (pc_hold == idex_bubble));

    // R7
    single_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_hold |=> !pc_hold);

    // R8
    flush_kills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ex_br_taken |=> !ex_we);

    // R5
    zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rs == 5'd0) |-> (fwd_a == 2'b00));

    // R2
    no_load_mem_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_is_load |-> ((fwd_a != 2'b10) && (fwd_b != 2'b10)));
endmodule

bind pipe_hazard_ctl hz_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fwd_a       (fwd_a),
    .fwd_b       (fwd_b),
    .pc_hold     (pc_hold),
    .ifid_hold   (ifid_hold),
    .idex_bubble (idex_bubble),
    .ifid_flush  (ifid_flush),
    .ex_br_taken (ex_br_taken),
    .ex_we       (ex_we),
    .ex_rs       (ex_rs),
    .mem_is_load (mem_is_load)
);

// File: tb/tb_pipe_hazard_ctl.sv
`timescale 1ns/1ps
module tb_pipe_hazard_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] id_rs = '0, id_rt = '0, id_rd = '0;
    logic [1:0] id_wa_sel = '0;
    logic       id_reg_we = 1'b0, id_is_load = 1'b0, ex_br_taken = 1'b0;
    logic [1:0] fwd_a, fwd_b;
    logic       pc_hold, ifid_hold, idex_bubble, ifid_flush, idex_flush;
    logic [4:0] wb_wa;
    logic       wb_we;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    pipe_hazard_ctl dut (.*);

    // vector: dest[20:16] we[15] gap2[14] rs[13:9] rt[8:4] exp_a[3:2] exp_b[1:0]
    localparam int NV = 8;
    localparam logic [20:0] VEC [NV] = '{
        {5'd5,  1'b1, 1'b0, 5'd5, 5'd7,  2'b10, 2'b00},  // R2
        {5'd7,  1'b1, 1'b0, 5'd3, 5'd7,  2'b00, 2'b10},  // R2
        {5'd9,  1'b1, 1'b1, 5'd9, 5'd9,  2'b01, 2'b01},  // R3
        {5'd0,  1'b1, 1'b0, 5'd0, 5'd0,  2'b00, 2'b00},  // R5
        {5'd4,  1'b0, 1'b0, 5'd4, 5'd4,  2'b00, 2'b00},  // R5
        {5'd6,  1'b0, 1'b1, 5'd6, 5'd6,  2'b00, 2'b00},  // R5
        {5'd12, 1'b1, 1'b1, 5'd1, 5'd12, 2'b00, 2'b01},  // R3
        {5'd3,  1'b1, 1'b0, 5'd2, 5'd8,  2'b00, 2'b00}   // R3
    };

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic set_id(input logic [4:0] rs, input logic [4:0] rt, input logic [4:0] rd,
                          input logic [1:0] sel, input logic we, input logic ld);
        id_rs = rs; id_rt = rt; id_rd = rd; id_wa_sel = sel;
        id_reg_we = we; id_is_load = ld;
    endtask

    task automatic nop();
        set_id(5'd0, 5'd0, 5'd0, 2'b00, 1'b0, 1'b0);
    endtask

    task automatic drain();
        nop();
        ex_br_taken = 1'b0;
        repeat (3) tick();
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog R10 actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // R10: reset state
        #4;
        chk("R10 wb_we in reset", {7'd0, wb_we}, 8'd0);
        chk("R10 fwd_a in reset", {6'd0, fwd_a}, 8'd0);
        chk("R10 hold in reset", {5'd0, pc_hold, idex_bubble, ifid_flush}, 8'd0);
        tick();
        rst_n = 1'b1;
        tick();
        chk("R10 wb_we after reset", {7'd0, wb_we}, 8'd0);
        chk("R10 fwd_b after reset", {6'd0, fwd_b}, 8'd0);

        // table of producer/consumer pairs (R2, R3, R5)
        for (int i = 0; i < NV; i++) begin
            logic [20:0] v;
            v = VEC[i];
            drain();
            set_id(5'd0, 5'd0, v[20:16], 2'b00, v[15], 1'b0);
            tick();
            if (v[14]) begin
                nop();
                tick();
            end
            set_id(v[13:9], v[8:4], 5'd0, 2'b00, 1'b0, 1'b0);
            #1;
            chk($sformatf("R11/R5 no stall vec%0d", i), {7'd0, pc_hold}, 8'd0);
            tick();
            chk($sformatf("R2/R3/R5 fwd_a vec%0d", i), {6'd0, fwd_a}, {6'd0, v[3:2]});
            chk($sformatf("R2/R3/R5 fwd_b vec%0d", i), {6'd0, fwd_b}, {6'd0, v[1:0]});
        end

        // R4: both stages match, younger wins
        drain();
        set_id(5'd0, 5'd0, 5'd5, 2'b00, 1'b1, 1'b0); tick();
        set_id(5'd0, 5'd0, 5'd5, 2'b00, 1'b1, 1'b0); tick();
        set_id(5'd5, 5'd0, 5'd0, 2'b00, 1'b0, 1'b0); tick();
        chk("R4 fwd_a both match", {6'd0, fwd_a}, 8'd2);
        chk("R4 fwd_b none", {6'd0, fwd_b}, 8'd0);

        // R1: destination choices reach write-back after three edges
        for (int s = 0; s < 4; s++) begin
            logic [4:0] exp_wa;
            exp_wa = (s == 0) ? 5'd10 : (s == 1) ? 5'd20 : (s == 2) ? 5'd31 : 5'd27;
            drain();
            set_id(5'd1, 5'd20, 5'd10, s[1:0], 1'b1, 1'b0);
            tick();
            nop();
            tick();
            tick();
            chk($sformatf("R1 wb_wa sel%0d", s), {3'd0, wb_wa}, {3'd0, exp_wa});
            chk($sformatf("R1 wb_we sel%0d", s), {7'd0, wb_we}, 8'd1);
        end

        // R6/R7: load-use stall on rs
        drain();
        set_id(5'd0, 5'd0, 5'd8, 2'b00, 1'b1, 1'b1); tick();
        set_id(5'd8, 5'd3, 5'd0, 2'b00, 1'b0, 1'b0); #1;
        chk("R6 stall outputs rs", {5'd0, pc_hold, ifid_hold, idex_bubble}, 8'd7);
        tick();
        chk("R7 stall one cycle", {7'd0, pc_hold}, 8'd0);
        tick();
        chk("R7 bypass after bubble", {6'd0, fwd_a}, 8'd1);

        // R6: load-use stall on rt
        drain();
        set_id(5'd0, 5'd0, 5'd9, 2'b00, 1'b1, 1'b1); tick();
        set_id(5'd2, 5'd9, 5'd0, 2'b00, 1'b0, 1'b0); #1;
        chk("R6 stall outputs rt", {5'd0, pc_hold, ifid_hold, idex_bubble}, 8'd7);

        // R5: load to register 0, and load with write enable low
        drain();
        set_id(5'd0, 5'd0, 5'd0, 2'b00, 1'b1, 1'b1); tick();
        set_id(5'd0, 5'd0, 5'd0, 2'b00, 1'b0, 1'b0); #1;
        chk("R5 load dest0 no stall", {7'd0, pc_hold}, 8'd0);
        drain();
        set_id(5'd0, 5'd0, 5'd8, 2'b00, 1'b0, 1'b1); tick();
        set_id(5'd8, 5'd8, 5'd0, 2'b00, 1'b0, 1'b0); #1;
        chk("R5 load we0 no stall", {7'd0, pc_hold}, 8'd0);

        // R11: non-load producer in ALU stage
        drain();
        set_id(5'd0, 5'd0, 5'd8, 2'b00, 1'b1, 1'b0); tick();
        set_id(5'd8, 5'd0, 5'd0, 2'b00, 1'b0, 1'b0); #1;
        chk("R11 alu producer no stall", {5'd0, pc_hold, ifid_hold, idex_bubble}, 8'd0);

        // R8: flush kills the decode instruction
        drain();
        set_id(5'd0, 5'd0, 5'd14, 2'b00, 1'b1, 1'b0);
        ex_br_taken = 1'b1; #1;
        chk("R8 flush outputs", {6'd0, ifid_flush, idex_flush}, 8'd3);
        tick();
        ex_br_taken = 1'b0;
        nop();
        tick();
        tick();
        chk("R8 flushed never writes", {7'd0, wb_we}, 8'd0);

        // R9: flush and load-use in the same cycle
        drain();
        set_id(5'd0, 5'd0, 5'd8, 2'b00, 1'b1, 1'b1); tick();
        set_id(5'd8, 5'd0, 5'd0, 2'b00, 1'b0, 1'b0);
        ex_br_taken = 1'b1; #1;
        chk("R9 no hold under flush", {5'd0, pc_hold, ifid_hold, idex_bubble}, 8'd0);
        chk("R9 flush wins", {6'd0, ifid_flush, idex_flush}, 8'd3);
        tick();
        ex_br_taken = 1'b0;
        drain();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule